// File: doc/BRIEF.md
# Dual-Channel Sample Port Deinterleaver

This block sits in front of a pair of DAC channels, I and Q, and turns incoming sample words into aligned I/Q pairs. In dual-bus mode each channel has its own input bus, both words arrive on the same clock edge, and they are registered together. In shared-bus mode one bus carries I and Q words alternately. A steering input tags every word as I (high) or Q (low). A holding register keeps the first word of a pair until its partner arrives.

A configuration bit sets which word of the interleaved stream opens a pair. The steering level still decides the channel for each word. In dual-bus mode the steering input has a second job: it acts as a datapath enable. Every output is registered, so no combinational path runs from an input to an output.

Top module: `iq_deint_port`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the edge sets `ch_i` and `ch_q` to 0, clears `out_vld` and `pair_err`, and empties the holding register.
- R2: In dual-bus mode (`cfg_shared`=0) with `steer`=1 at an edge, the next outputs are `ch_i`=`bus_a`, `ch_q`=`bus_b` and `out_vld`=1.
- R3: In dual-bus mode with `steer`=0 at an edge, `out_vld` is 0 afterwards and `ch_i`/`ch_q` keep their previous values.
- R4: In shared-bus mode (`cfg_shared`=1), a `bus_a` word sampled with `steer`=1 appears only on `ch_i`, and a word sampled with `steer`=0 appears only on `ch_q`. `bus_b` is ignored.
- R5: With `cfg_qlead`=0, a pair opens with a `steer`=0 word. The next `steer`=1 word completes it.
- R6: With `cfg_qlead`=1, a pair opens with a `steer`=1 word and a following `steer`=0 word completes it. The channel assignment of R4 is unchanged.
- R7: In shared-bus mode, `out_vld` is high for exactly one cycle per completed pair, so it is never high on two consecutive cycles. Outputs hold between pairs.
- R8: In shared-bus mode, a word whose steering level equals the previous word's level raises `pair_err` for one cycle. This covers an opening-level word while a word is pending, where the new word replaces the pending one, and a closing-level word with nothing pending, where the word is dropped.
- R9: An edge at which `cfg_shared` or `cfg_qlead` differs from its value at the previous edge empties the holding register before the word on that edge is processed.
- R10: Outputs change only at rising edges, one edge after the inputs that caused them are sampled.
- R11: `pair_err` stays 0 for words sampled in dual-bus mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; words are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_shared | input | 1 | 0 = dual-bus mode, 1 = shared-bus interleaved mode |
| cfg_qlead | input | 1 | Pairing order in shared-bus mode: 0 = Q word opens a pair, 1 = I word opens a pair |
| steer | input | 1 | Channel tag in shared-bus mode (1 = I, 0 = Q); datapath enable in dual-bus mode |
| bus_a | input | WORD_W | Port 1 data: the I bus in dual-bus mode, the interleaved bus in shared-bus mode |
| bus_b | input | WORD_W | Port 2 data: the Q bus in dual-bus mode |
| ch_i | output | WORD_W | Registered I channel word |
| ch_q | output | WORD_W | Registered Q channel word |
| out_vld | output | 1 | One-cycle strobe: a new I/Q pair is on `ch_i`/`ch_q` |
| pair_err | output | 1 | One-cycle flag: a steering-order violation in shared-bus mode |

## Verification
The assertions assume that the configuration and steering inputs are stable, known values at each rising edge and that reset is applied before the first data edge. The bench meets this by changing every input on the falling clock edge and by holding reset for several cycles at the start. Within those limits the stimulus is deliberately hostile. It switches mode and pairing order while a word is pending, sends repeated steering levels and lone closing words, toggles the enable in dual-bus mode, and resets in the middle of a stream. Each output is compared every cycle with a queue-based model of the pairing rules.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;
   // input port organisation selected by cfg_shared
   typedef enum logic {
      PORT_DUAL   = 1'b0,
      PORT_SHARED = 1'b1
   } port_mode_e;

   // output channel indices
   localparam int CH_I   = 0;
   localparam int CH_Q   = 1;
   localparam int NUM_CH = 2;
endpackage

// File: rtl/iq_cfg_watch.sv
// Detects a change of the configuration bits between consecutive edges.
module iq_cfg_watch #(
   parameter int CFG_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CFG_W-1:0] cfg,
   output logic             cfg_chg
);
   logic [CFG_W-1:0] cfg_prev;

   always_ff @(posedge clk) begin
      cfg_prev <= cfg;
   end

   // a reset edge re-arms the reference, so no change is reported after it
   assign cfg_chg = !rst && (cfg != cfg_prev);
endmodule

// File: rtl/iq_pair_tracker.sv
// Holding register and pairing decision for shared-bus mode.
module iq_pair_tracker #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shared_en,
   input  logic              qlead,
   input  logic              cfg_chg,
   input  logic              steer,
   input  logic [WORD_W-1:0] word,
   output logic              fire,
   output logic              err,
   output logic [WORD_W-1:0] pair_i,
   output logic [WORD_W-1:0] pair_q
);
   logic              hold_vld;
   logic [WORD_W-1:0] hold_word;
   logic              pend;
   logic              opens;

   // a configuration change discards whatever is pending
   assign pend  = hold_vld && !cfg_chg;
   // the opening steering level equals qlead
   assign opens = (steer == qlead);

   assign fire   = shared_en && !opens && pend;
   assign err    = shared_en && (opens ? pend : !pend);
   assign pair_i = steer ? word : hold_word;
   assign pair_q = steer ? hold_word : word;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_vld  <= 1'b0;
         hold_word <= '0;
      end else if (shared_en) begin
         hold_vld <= opens;
         if (opens) begin
            hold_word <= word;
         end
      end else begin
         hold_vld <= pend;
      end
   end
endmodule

// File: rtl/iq_out_stage.sv
// Registered channel outputs, valid strobe and error flag.
module iq_out_stage
   import iq_deint_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              err_in,
   input  logic [WORD_W-1:0] din [NUM_CH],
   output logic [WORD_W-1:0] dout [NUM_CH],
   output logic              vld,
   output logic              err
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (rst) begin
            dout[c] <= '0;
         end else if (load) begin
            dout[c] <= din[c];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld <= 1'b0;
         err <= 1'b0;
      end else begin
         vld <= load;
         err <= err_in;
      end
   end
endmodule

// File: rtl/iq_deint_port.sv
module iq_deint_port
   import iq_deint_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_shared,
   input  logic              cfg_qlead,
   input  logic              steer,
   input  logic [WORD_W-1:0] bus_a,
   input  logic [WORD_W-1:0] bus_b,
   output logic [WORD_W-1:0] ch_i,
   output logic [WORD_W-1:0] ch_q,
   output logic              out_vld,
   output logic              pair_err
);
   localparam int CFG_W = 2;

   if (WORD_W < 2) begin : g_bad_width
      $error("iq_deint_port: WORD_W must be at least 2");
   end

   port_mode_e        mode;
   logic              cfg_chg;
   logic              sh_fire, sh_err, dual_fire, load;
   logic [WORD_W-1:0] sh_i, sh_q;
   logic [WORD_W-1:0] din  [NUM_CH];
   logic [WORD_W-1:0] dout [NUM_CH];

   assign mode = port_mode_e'(cfg_shared);

   iq_cfg_watch #(.CFG_W(CFG_W)) u_watch (
      .clk     (clk),
      .rst     (rst),
      .cfg     ({cfg_shared, cfg_qlead}),
      .cfg_chg (cfg_chg)
   );

   iq_pair_tracker #(.WORD_W(WORD_W)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .shared_en (mode == PORT_SHARED),
      .qlead     (cfg_qlead),
      .cfg_chg   (cfg_chg),
      .steer     (steer),
      .word      (bus_a),
      .fire      (sh_fire),
      .err       (sh_err),
      .pair_i    (sh_i),
      .pair_q    (sh_q)
   );

   // in dual-bus mode the steering input acts as datapath enable
   assign dual_fire = (mode == PORT_DUAL) && steer;
   assign load      = dual_fire || sh_fire;

   always_comb begin
      if (mode == PORT_DUAL) begin
         din[CH_I] = bus_a;
         din[CH_Q] = bus_b;
      end else begin
         din[CH_I] = sh_i;
         din[CH_Q] = sh_q;
      end
   end

   iq_out_stage #(.WORD_W(WORD_W)) u_out (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .err_in (sh_err),
      .din    (din),
      .dout   (dout),
      .vld    (out_vld),
      .err    (pair_err)
   );

   assign ch_i = dout[CH_I];
   assign ch_q = dout[CH_Q];
endmodule

// File: rtl/iq_deint_chk.sv
module iq_deint_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_shared,
   input logic              steer,
   input logic [WORD_W-1:0] bus_a,
   input logic [WORD_W-1:0] bus_b,
   input logic [WORD_W-1:0] ch_i,
   input logic [WORD_W-1:0] ch_q,
   input logic              out_vld,
   input logic              pair_err
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_vld && !pair_err && ch_i == '0 && ch_q == '0));

   // R2
   dual_stream_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && !cfg_shared && steer) |->
         (out_vld && ch_i == $past(bus_a) && ch_q == $past(bus_b)));

   // R3
   dual_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && !cfg_shared && !steer) |->
         (!out_vld && $stable(ch_i) && $stable(ch_q)));

   // R7
   single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(out_vld)) |-> !($past(cfg_shared) && $past(cfg_shared, 2)));

   // R8
   err_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(out_vld && pair_err));

   // R11
   dual_no_err_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!cfg_shared) |-> !pair_err);
endmodule

bind iq_deint_port iq_deint_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cfg_shared (cfg_shared),
   .steer      (steer),
   .bus_a      (bus_a),
   .bus_b      (bus_b),
   .ch_i       (ch_i),
   .ch_q       (ch_q),
   .out_vld    (out_vld),
   .pair_err   (pair_err)
);

// File: tb/iq_deint_port_test.sv
`timescale 1ns/1ps
module iq_deint_port_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cfg_shared = 1'b0;
   logic         cfg_qlead = 1'b0;
   logic         steer = 1'b0;
   logic [W-1:0] bus_a = '0;
   logic [W-1:0] bus_b = '0;
   logic [W-1:0] ch_i, ch_q;
   logic         out_vld, pair_err;

   int checks = 0;
   int fails  = 0;
   bit timed_out = 0;

   always #10 clk = ~clk;

   iq_deint_port #(.WORD_W(W)) uut (
      .clk(clk), .rst(rst), .cfg_shared(cfg_shared), .cfg_qlead(cfg_qlead),
      .steer(steer), .bus_a(bus_a), .bus_b(bus_b),
      .ch_i(ch_i), .ch_q(ch_q), .out_vld(out_vld), .pair_err(pair_err)
   );

   // behavioural reference model
   logic [W-1:0] pend_q [$];
   logic [W-1:0] exp_i = '0, exp_q = '0;
   bit           exp_v = 0, exp_e = 0;
   bit           ref_sh = 0, ref_ql = 0;
   string        tag = "R1";
   bit           model_on = 0;

   always @(posedge clk) begin
      if (rst) begin
         exp_i = '0; exp_q = '0; exp_v = 0; exp_e = 0;
         pend_q.delete();
         ref_sh = cfg_shared; ref_ql = cfg_qlead;
         tag = "R1";
      end else begin
         exp_v = 0; exp_e = 0;
         if (cfg_shared != ref_sh || cfg_qlead != ref_ql) begin
            pend_q.delete();   // R9
            tag = "R9";
         end else begin
            tag = "";
         end
         ref_sh = cfg_shared; ref_ql = cfg_qlead;
         if (!cfg_shared) begin
            if (steer) begin
               exp_i = bus_a; exp_q = bus_b; exp_v = 1;
               tag = {tag, " R2 R10 R11"};
            end else begin
               tag = {tag, " R3 R11"};
            end
         end else if (steer == cfg_qlead) begin
            if (pend_q.size() > 0) begin
               exp_e = 1;
               pend_q.delete();
               tag = {tag, " R8"};
            end else begin
               tag = {tag, cfg_qlead ? " R6" : " R5"};
            end
            pend_q.push_back(bus_a);
         end else begin
            if (pend_q.size() > 0) begin
               logic [W-1:0] first;
               first = pend_q.pop_front();
               if (steer) begin exp_i = bus_a; exp_q = first; end
               else       begin exp_i = first; exp_q = bus_a; end
               exp_v = 1;
               tag = {tag, cfg_qlead ? " R6 R4 R7 R10" : " R5 R4 R7 R10"};
            end else begin
               exp_e = 1;
               tag = {tag, " R8"};
            end
         end
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         checks++;
         if (ch_i !== exp_i || ch_q !== exp_q || out_vld !== exp_v || pair_err !== exp_e) begin
            fails++;
            $display("FAIL [%s] i=%h q=%h v=%b e=%b expected i=%h q=%h v=%b e=%b",
                     tag, ch_i, ch_q, out_vld, pair_err, exp_i, exp_q, exp_v, exp_e);
         end
      end
   end

   task automatic word(input bit sh, input bit ql, input bit st,
                       input logic [W-1:0] a, input logic [W-1:0] b);
      cfg_shared = sh; cfg_qlead = ql; steer = st; bus_a = a; bus_b = b;
      @(negedge clk);
   endtask

   task automatic stimulus();
      repeat (3) @(negedge clk);
      model_on = 1;          // R1 reset state compared while rst high
      @(negedge clk);
      rst = 0;
      // R2 / R3 dual-bus streaming and enable gating
      word(0, 0, 1, 16'h1111, 16'h2222);
      word(0, 0, 1, 16'h3333, 16'h4444);
      word(0, 0, 0, 16'hdead, 16'hbeef);
      word(0, 0, 0, 16'h0bad, 16'hf00d);
      word(0, 0, 1, 16'h5555, 16'h6666);
      // R5 shared bus, Q word opens
      word(1, 0, 0, 16'h00a1, 16'hffff);
      word(1, 0, 1, 16'h00b1, 16'hffff);
      word(1, 0, 0, 16'h00a2, 16'h0000);
      word(1, 0, 1, 16'h00b2, 16'h0000);
      // R8 repeated opening level, then lone closing word
      word(1, 0, 0, 16'h0c01, 16'h0);
      word(1, 0, 0, 16'h0c02, 16'h0);
      word(1, 0, 1, 16'h0c03, 16'h0);
      word(1, 0, 1, 16'h0c04, 16'h0);
      // R9 switch pairing order while a Q word is pending
      word(1, 0, 0, 16'h0d01, 16'h0);
      word(1, 1, 0, 16'h0d02, 16'h0);
      // R6 I word opens
      word(1, 1, 1, 16'h0e01, 16'h0);
      word(1, 1, 0, 16'h0e02, 16'h0);
      word(1, 1, 1, 16'h0e03, 16'h0);
      word(1, 1, 1, 16'h0e04, 16'h0);
      word(1, 1, 0, 16'h0e05, 16'h0);
      // R9 leave to dual with pending word, come back
      word(1, 1, 1, 16'h0f01, 16'h0);
      word(0, 1, 0, 16'h0f02, 16'h0f03);
      word(1, 1, 0, 16'h0f04, 16'h0);
      // random traffic in every mode
      for (int n = 0; n < 2000; n++) begin
         bit sh, ql;
         sh = (n / 400) % 2 == 1 ? 1'b1 : 1'b0;
         ql = (n / 200) % 2 == 1 ? 1'b1 : 1'b0;
         if ($urandom_range(0, 49) == 0) sh = ~sh;
         word(sh, ql, ($urandom_range(0, 5) != 0) ^ n[0],
              W'($urandom), W'($urandom));
      end
      // R1 reset in mid-stream with a pending word
      word(1, 0, 0, 16'h7777, 16'h0);
      rst = 1;
      word(1, 0, 1, 16'h8888, 16'h0);
      word(1, 0, 1, 16'h9999, 16'h0);
      rst = 0;
      word(1, 0, 1, 16'haaaa, 16'h0);
      word(1, 0, 0, 16'hbbbb, 16'h0);
      word(1, 0, 1, 16'hcccc, 16'h0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      fork
         stimulus();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         fails++;
         $display("FAIL [watchdog] run did not finish, expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule